// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial two-wire bus slave that gives a host processor read and write access to a bank of 22 eight-bit configuration registers. It answers only at its fixed 7-bit address 69h, which is D2h for writes and D3h for reads in 8-bit form. It supports two transaction styles. In byte style, the command byte selects one register, and the command value is the register index plus one. In block style, the command byte is 00h and the transfer runs through consecutive registers starting at register 0, with a byte count in front of the data. The slave pulls the data line low and never drives it high.

Every register bit is either writable or read-only. The stored bank loads fixed defaults at reset and is presented to the rest of the chip as one flat vector. A few read-only fields do not return stored values on a read. Instead they return live status from outside the block: the latched frequency strap pins, the watchdog expiry flag and the running watchdog down-count.

The bus inputs are sampled with the system clock, which must run much faster than the bus clock. Start and stop conditions are detected on the sampled lines.

Top module: `smbus_cfg_slave`

## Requirements
- R1: A first byte whose upper seven bits differ from 69h is not acknowledged, and the transfer has no effect on any register. A byte of D2h or D3h is acknowledged.
- R2: A byte write is address D2h, command N from 1 to 22, then one data byte. All three bytes are acknowledged and the data goes to register N-1, subject to that register's read-only mask.
- R3: A byte read is address D2h, command N, a repeated start, address D3h, then one byte returned by the slave. The returned byte is the read value of register N-1.
- R4: A block write is address D2h, command 00h, a count byte C, then data. The count is acknowledged. The first C data bytes are acknowledged and stored from register 0 upward. Data byte C+1 is not acknowledged.
- R5: In a block write, data bytes within the count that fall beyond register 21 are acknowledged but change no register.
- R6: A block read is address D2h, command 00h, a repeated start, then address D3h. The slave first returns the count 16h (22). It then returns registers 0, 1, 2 and so on for as long as the master acknowledges. Any byte past register 21 reads FFh.
- R7: A command byte above 22 (16h) is not acknowledged.
- R8: Register 7 always reads 22h and ignores writes. Register 1 bits 4..0 read the strap input and ignore writes. Register 5 bit 5 reads the watchdog expiry input and ignores writes. All other bits of registers 1 and 5 are writable.
- R9: Register 20 bits 6..0 read the live watchdog count while the watchdog-active input is high. Otherwise all of register 20 reads its stored value. Bit 7 always reads the stored value.
- R10: After reset the stored registers 0 to 21 hold, in order: 10h, E7h, FFh, FFh, FFh, 02h, FEh, 22h, D0h, 7Ah, 3Bh, 0Bh, 72h, 0Fh, 10h, ECh, E4h, 00h, 00h, DAh, 88h, 4Bh.
- R11: The data output is open-drain. The pull-down changes only while the bus clock is low. After a stop condition the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 5 | Latched frequency strap value, read through register 1 bits 4..0 |
| wd_fired_i | input | 1 | Watchdog expiry flag, read through register 5 bit 5 |
| wd_active_i | input | 1 | Watchdog running, selects the live count for register 20 |
| wd_count_i | input | 7 | Live watchdog down-count |
| cfg_o | output | 176 | Stored register bank, register k at bits 8k+7..8k |

## Verification
Two functions can act on the same byte. One is the storage of a write into a register that has read-only bits. The other is the live-status overlay that a later read of that register returns. The bench writes all-ones and all-zeros into registers 1, 5, 7 and 20 while the strap, expiry flag and watchdog inputs hold values that differ from the stored defaults. It then reads those registers back in both byte and block style. A read is correct only if the writable bits come from the write and the read-only bits come from the live inputs. The flat register image must never show a change in a read-only stored bit.

// File: rtl/smbreg_pkg.sv
`timescale 1ns/1ps
package smbreg_pkg;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_RX_ACK,
        LS_TX,
        LS_TX_ACK
    } link_state_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_CMD,
        BY_CNT,
        BY_DATA
    } rx_kind_e;

    // Events decoded from the sampled bus lines, valid for one clock.
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    // Live status fields that override stored bits on a read.
    typedef struct packed {
        logic [4:0] strap;
        logic       wd_fired;
        logic       wd_active;
        logic [6:0] wd_count;
    } live_status_t;

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            0:  return 8'h10;
            1:  return 8'hE7;
            2:  return 8'hFF;
            3:  return 8'hFF;
            4:  return 8'hFF;
            5:  return 8'h02;
            6:  return 8'hFE;
            7:  return 8'h22;
            8:  return 8'hD0;
            9:  return 8'h7A;
            10: return 8'h3B;
            11: return 8'h0B;
            12: return 8'h72;
            13: return 8'h0F;
            14: return 8'h10;
            15: return 8'hEC;
            16: return 8'hE4;
            19: return 8'hDA;
            20: return 8'h88;
            21: return 8'h4B;
            default: return 8'h00;
        endcase
    endfunction

    // A set bit marks a bit that a bus write may not change.
    function automatic logic [7:0] ro_mask(input int idx);
        case (idx)
            1:  return 8'h1F;
            5:  return 8'h20;
            7:  return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sampler.sv
`timescale 1ns/1ps
module smb_line_sampler
    import smbreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_s;
    logic [SYNC_STAGES-1:0] sda_s;
    logic                   scl_p;
    logic                   sda_p;
    logic                   scl_c;
    logic                   sda_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= '1;
            sda_s <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
            sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
            scl_p <= scl_c;
            sda_p <= sda_c;
        end
    end

    assign scl_c = scl_s[SYNC_STAGES-1];
    assign sda_c = sda_s[SYNC_STAGES-1];

    always_comb begin
        evt.rise  = scl_c & ~scl_p;
        evt.fall  = ~scl_c & scl_p;
        evt.start = scl_c & scl_p & sda_p & ~sda_c;
        evt.stop  = scl_c & scl_p & ~sda_p & sda_c;
        evt.sda   = sda_c;
    end
endmodule

// File: rtl/smb_cfg_bank.sv
`timescale 1ns/1ps
module smb_cfg_bank
    import smbreg_pkg::*;
#(
    parameter int NREG = 22,
    parameter int PTRW = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTRW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PTRW-1:0]   rd_idx,
    input  live_status_t      st,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] cfg_flat
);
    logic [7:0] bank [NREG];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (rst) begin
                bank[k] <= reset_value(k);
            end else if (wr_en && int'(wr_idx) == k) begin
                bank[k] <= (bank[k] & ro_mask(k)) | (wr_data & ~ro_mask(k));
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign cfg_flat[g*8 +: 8] = bank[g];
    end

    // Read path: stored value with live status laid over read-only fields.
    always_comb begin
        rd_data = 8'hFF;
        if (int'(rd_idx) < NREG) begin
            rd_data = bank[rd_idx];
            if (int'(rd_idx) == 1) rd_data[4:0] = st.strap;
            if (int'(rd_idx) == 5) rd_data[5]   = st.wd_fired;
            if (int'(rd_idx) == 20 && st.wd_active) rd_data[6:0] = st.wd_count;
        end
    end
endmodule

// File: rtl/smb_link_fsm.sv
`timescale 1ns/1ps
module smb_link_fsm
    import smbreg_pkg::*;
#(
    parameter int         NREG     = 22,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         PTRW     = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  bus_evt_t        evt,
    input  logic [7:0]      rd_data,
    output logic            sda_pull,
    output logic            wr_en,
    output logic [PTRW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic [PTRW-1:0] rd_idx
);
    link_state_e     state;
    rx_kind_e        kind;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [7:0]      txreg;
    logic [PTRW-1:0] ptr;
    logic [7:0]      wr_left;
    logic            blk_mode;
    logic            go_tx;
    logic            send_cnt;
    logic            mack;
    logic            dec_ack;
    logic            byte_done;
    logic [7:0]      tx_byte;
    logic            ptr_in_bank;

    assign ptr_in_bank = int'(ptr) < NREG;
    assign byte_done   = (state == LS_RX) && evt.fall && (bitcnt == 4'd8);
    assign tx_byte     = send_cnt ? 8'(NREG) : rd_data;

    always_comb begin
        dec_ack = 1'b0;
        case (kind)
            BY_ADDR: dec_ack = (shreg[7:1] == DEV_ADDR);
            BY_CMD:  dec_ack = (shreg == 8'h00) || (int'(shreg) <= NREG);
            BY_CNT:  dec_ack = 1'b1;
            BY_DATA: dec_ack = (wr_left != 8'h00);
            default: dec_ack = 1'b0;
        endcase
    end

    assign wr_en   = byte_done && (kind == BY_DATA) && (wr_left != 8'h00) && ptr_in_bank;
    assign wr_idx  = ptr;
    assign wr_data = shreg;
    assign rd_idx  = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LS_IDLE;
            kind     <= BY_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            wr_left  <= '0;
            blk_mode <= 1'b1;
            go_tx    <= 1'b0;
            send_cnt <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
        end else if (evt.stop) begin
            state    <= LS_IDLE;
            sda_pull <= 1'b0;
        end else if (evt.start) begin
            state    <= LS_RX;
            kind     <= BY_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                LS_RX: begin
                    if (evt.rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        go_tx <= 1'b0;
                        case (kind)
                            BY_ADDR: begin
                                if (shreg[0]) begin
                                    go_tx    <= 1'b1;
                                    send_cnt <= blk_mode;
                                end else begin
                                    kind <= BY_CMD;
                                end
                            end
                            BY_CMD: begin
                                if (shreg == 8'h00) begin
                                    blk_mode <= 1'b1;
                                    ptr      <= '0;
                                    kind     <= BY_CNT;
                                end else begin
                                    blk_mode <= 1'b0;
                                    ptr      <= PTRW'(shreg - 8'd1);
                                    wr_left  <= 8'd1;
                                    kind     <= BY_DATA;
                                end
                            end
                            BY_CNT: begin
                                wr_left <= shreg;
                                kind    <= BY_DATA;
                            end
                            default: begin
                                if (wr_left != 8'h00) begin
                                    wr_left <= wr_left - 8'd1;
                                    if (ptr_in_bank) ptr <= ptr + 1'b1;
                                end
                            end
                        endcase
                        state    <= dec_ack ? LS_RX_ACK : LS_IDLE;
                        sda_pull <= dec_ack;
                    end
                end
                LS_RX_ACK: begin
                    if (evt.fall) begin
                        if (go_tx) begin
                            state    <= LS_TX;
                            txreg    <= tx_byte;
                            sda_pull <= ~tx_byte[7];
                            bitcnt   <= 4'd1;
                            if (send_cnt)         send_cnt <= 1'b0;
                            else if (ptr_in_bank) ptr      <= ptr + 1'b1;
                        end else begin
                            state    <= LS_RX;
                            bitcnt   <= '0;
                            sda_pull <= 1'b0;
                        end
                    end
                end
                LS_TX: begin
                    if (evt.fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_pull <= 1'b0;
                            state    <= LS_TX_ACK;
                        end else begin
                            sda_pull <= ~txreg[6];
                            txreg    <= {txreg[6:0], 1'b0};
                            bitcnt   <= bitcnt + 4'd1;
                        end
                    end
                end
                LS_TX_ACK: begin
                    if (evt.rise) begin
                        mack <= ~evt.sda;
                    end else if (evt.fall) begin
                        if (mack) begin
                            state    <= LS_TX;
                            txreg    <= tx_byte;
                            sda_pull <= ~tx_byte[7];
                            bitcnt   <= 4'd1;
                            if (send_cnt)         send_cnt <= 1'b0;
                            else if (ptr_in_bank) ptr      <= ptr + 1'b1;
                        end else begin
                            state    <= LS_IDLE;
                            sda_pull <= 1'b0;
                        end
                    end
                end
                default: sda_pull <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/smbus_cfg_slave.sv
`timescale 1ns/1ps
module smbus_cfg_slave
    import smbreg_pkg::*;
#(
    parameter int         NUM_REGS = 22,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    input  logic [4:0]            strap_i,
    input  logic                  wd_fired_i,
    input  logic                  wd_active_i,
    input  logic [6:0]            wd_count_i,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int PTRW = $clog2(NUM_REGS + 1);

    bus_evt_t        evt;
    live_status_t    st;
    logic            wr_en;
    logic [PTRW-1:0] wr_idx;
    logic [7:0]      wr_data;
    logic [PTRW-1:0] rd_idx;
    logic [7:0]      rd_data;

    assign st = '{strap: strap_i, wd_fired: wd_fired_i,
                  wd_active: wd_active_i, wd_count: wd_count_i};

    smb_line_sampler #(.SYNC_STAGES(2)) i_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    smb_link_fsm #(.NREG(NUM_REGS), .DEV_ADDR(DEV_ADDR), .PTRW(PTRW)) i_link (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .rd_data  (rd_data),
        .sda_pull (sda_pull_o),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx)
    );

    smb_cfg_bank #(.NREG(NUM_REGS), .PTRW(PTRW)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .st       (st),
        .rd_data  (rd_data),
        .cfg_flat (cfg_o)
    );
endmodule

// File: rtl/smb_slave_checks.sv
`timescale 1ns/1ps
module smb_slave_checks #(
    parameter int NREG = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_pull_o,
    input logic [NREG*8-1:0] cfg_o
);
    // R10: stored values right after reset is released
    a_r10_reset_image: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_o[15:8] == 8'hE7 && cfg_o[63:56] == 8'h22 &&
                        cfg_o[167:160] == 8'h88 && cfg_o[175:168] == 8'h4B));

    // R8: stored read-only bits never move
    a_r8_ro_stable: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_o[63:56]) && $stable(cfg_o[12:8]) && $stable(cfg_o[45]));

    // R4: register writes land only while the bus clock is low
    a_r4_write_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_o) |-> !scl_i);

    // R11: the pull-down toggles only while the bus clock is low
    a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind smbus_cfg_slave smb_slave_checks #(.NREG(NUM_REGS)) i_checks (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .cfg_o      (cfg_o)
);

// File: tb/test_smbus_cfg_slave.sv
`timescale 1ns/1ps
module test_smbus_cfg_slave;
    localparam int NREG = 22;
    localparam int Q    = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic              scl;
    logic              sda_m;
    logic              sda_pull;
    logic [4:0]        strap;
    logic              fired;
    logic              wd_act;
    logic [6:0]        wd_cnt;
    logic [NREG*8-1:0] cfg;
    wire               sda_line = sda_m & ~sda_pull;

    int   errors = 0;
    int   checks = 0;
    bit   cmp_en = 1'b0;
    int   img_fails = 0;
    logic [7:0] mreg [NREG];

    smbus_cfg_slave i_smbus_cfg_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .strap_i     (strap),
        .wd_fired_i  (fired),
        .wd_active_i (wd_act),
        .wd_count_i  (wd_cnt),
        .cfg_o       (cfg)
    );

    function automatic logic [7:0] dflt(input int i);
        logic [7:0] t [NREG] = '{8'h10, 8'hE7, 8'hFF, 8'hFF, 8'hFF, 8'h02, 8'hFE, 8'h22,
                                 8'hD0, 8'h7A, 8'h3B, 8'h0B, 8'h72, 8'h0F, 8'h10, 8'hEC,
                                 8'hE4, 8'h00, 8'h00, 8'hDA, 8'h88, 8'h4B};
        return t[i];
    endfunction

    function automatic logic [7:0] fixed_bits(input int i);
        if (i == 7) return 8'hFF;
        if (i == 1) return 8'h1F;
        if (i == 5) return 8'h20;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd(input int i);
        logic [7:0] v;
        if (i >= NREG) return 8'hFF;
        v = mreg[i];
        if (i == 1) v[4:0] = strap;
        if (i == 5) v[5] = fired;
        if (i == 20 && wd_act) v[6:0] = wd_cnt;
        return v;
    endfunction

    task automatic mwrite(input int i, input logic [7:0] d);
        if (i < NREG) mreg[i] = (mreg[i] & fixed_bits(i)) | (d & ~fixed_bits(i));
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Register image against the model on every clock between transfers (R2, R4, R8)
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            for (int k = 0; k < NREG; k++) begin
                if (cfg[k*8 +: 8] !== mreg[k]) begin
                    errors++;
                    if (img_fails < 10)
                        $display("FAIL R2/R4 image reg %0d: got %02h expected %02h",
                                 k, cfg[k*8 +: 8], mreg[k]);
                    img_fails++;
                    break;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hung expected finished");
        report();
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_in(d[i]);
        bit_out(~give_ack);
    endtask

    task automatic byte_write(input int idx, input logic [7:0] d);
        logic a;
        cmp_en = 1'b0;
        bus_start();
        wr_byte(8'hD2, a);            chk("R1 own write address ACK", {7'd0, a}, 8'd1);
        wr_byte(8'(idx + 1), a);      chk("R2 byte write command ACK", {7'd0, a}, 8'd1);
        wr_byte(d, a);                chk("R2 byte write data ACK", {7'd0, a}, 8'd1);
        bus_stop();
        mwrite(idx, d);
        chk("R11 line released after stop", {7'd0, sda_pull}, 8'd0);
        cmp_en = 1'b1;
    endtask

    task automatic byte_read(input int idx, input string tag);
        logic a;
        logic [7:0] d;
        cmp_en = 1'b0;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'(idx + 1), a);      chk("R3 byte read command ACK", {7'd0, a}, 8'd1);
        bus_start();
        wr_byte(8'hD3, a);            chk("R1 own read address ACK", {7'd0, a}, 8'd1);
        rd_byte(1'b0, d);             chk(tag, d, exp_rd(idx));
        bus_stop();
        cmp_en = 1'b1;
    endtask

    task automatic block_write(input int cnt, input int nsend, input logic [7:0] base);
        logic a;
        cmp_en = 1'b0;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);            chk("R4 block command ACK", {7'd0, a}, 8'd1);
        wr_byte(8'(cnt), a);          chk("R4 block count ACK", {7'd0, a}, 8'd1);
        for (int k = 0; k < nsend; k++) begin
            wr_byte(base + 8'(k), a);
            if (k >= NREG && k < cnt) chk("R5 byte past last register ACK", {7'd0, a}, 8'd1);
            else chk("R4 data ACK within count only", {7'd0, a}, (k < cnt) ? 8'd1 : 8'd0);
            if (a && k < cnt) mwrite(k, base + 8'(k));
            if (!a) break;
        end
        bus_stop();
        cmp_en = 1'b1;
    endtask

    task automatic block_read(input int nread);
        logic a;
        logic [7:0] d;
        cmp_en = 1'b0;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        bus_start();
        wr_byte(8'hD3, a);
        rd_byte(1'b1, d);             chk("R6 block read count", d, 8'd22);
        for (int k = 0; k < nread; k++) begin
            rd_byte(k < nread - 1, d);
            chk($sformatf("R6 block read reg %0d", k), d, exp_rd(k));
        end
        bus_stop();
        cmp_en = 1'b1;
    endtask

    initial begin
        logic a;
        rst = 1'b1; scl = 1'b1; sda_m = 1'b1;
        strap = 5'h07; fired = 1'b0; wd_act = 1'b0; wd_cnt = 7'h00;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NREG; k++) begin
            chk($sformatf("R10 reset value reg %0d", k), cfg[k*8 +: 8], dflt(k));
            mreg[k] = dflt(k);
        end
        chk("R11 idle release", {7'd0, sda_pull}, 8'd0);
        cmp_en = 1'b1;

        // R1: foreign addresses are ignored
        cmp_en = 1'b0;
        bus_start(); wr_byte(8'hA0, a); chk("R1 foreign address NACK", {7'd0, a}, 8'd0);
        wr_byte(8'h01, a); chk("R1 no response after foreign address", {7'd0, a}, 8'd0);
        bus_stop();
        bus_start(); wr_byte(8'hD0, a); chk("R1 near-miss address NACK", {7'd0, a}, 8'd0);
        bus_stop();
        cmp_en = 1'b1;

        // R2 / R3: byte style
        byte_write(0, 8'hA5);
        byte_write(21, 8'h3C);
        byte_read(0, "R3 byte read reg 0");
        byte_read(9, "R3 byte read reg 9");
        byte_read(21, "R3 byte read reg 21");

        // R7: command out of range
        cmp_en = 1'b0;
        bus_start(); wr_byte(8'hD2, a); wr_byte(8'd23, a);
        chk("R7 command 23 NACK", {7'd0, a}, 8'd0);
        bus_stop();
        bus_start(); wr_byte(8'hD2, a); wr_byte(8'hFF, a);
        chk("R7 command FF NACK", {7'd0, a}, 8'd0);
        bus_stop();
        cmp_en = 1'b1;

        // R4: short block, byte after count refused
        block_write(3, 4, 8'h11);
        // R5: count past the bank, extras acknowledged but dropped
        block_write(24, 24, 8'h60);
        // R6: full readout plus one byte past the end
        block_read(NREG + 1);

        // R8: read-only fields under writes, with live status differing from storage
        strap = 5'h0A; fired = 1'b1;
        byte_write(1, 8'h00);
        byte_write(5, 8'hFF);
        byte_write(7, 8'h00);
        byte_read(1, "R8 strap overlay reg 1");
        byte_read(5, "R8 expiry overlay reg 5");
        byte_read(7, "R8 identification reg 7");
        fired = 1'b0;
        byte_write(5, 8'h00);
        byte_read(5, "R8 expiry overlay cleared reg 5");

        // R9: watchdog count overlay
        byte_write(20, 8'hFF);
        wd_act = 1'b1; wd_cnt = 7'h35;
        byte_read(20, "R9 live count reg 20");
        wd_act = 1'b0;
        byte_read(20, "R9 stored value reg 20");
        wd_act = 1'b1; wd_cnt = 7'h02; strap = 5'h15; fired = 1'b1;
        block_read(NREG);

        repeat (20) @(negedge clk);
        report();
    end
endmodule